// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is a management-bus master for Ethernet PHYs. Software, or a neighbouring block, starts a clause-22 transfer by writing one 32-bit access word. The word carries the start flag, the direction, both addresses and the write data. The controller then serialises a complete management frame on MDC/MDIO.

While the transfer runs, the start bit reads back as a busy flag. A caller polls the word until that bit returns to zero. On a read, the sixteen bits returned by the PHY replace the low half of the same word, so one final read of the register collects the result.

MDC is derived from the system clock by a divider parameter and stays low between transfers. MDIO changes only on the falling edge of MDC. Input data is sampled on the rising edge.

Top module: `mdio_access_ctrl`

## Requirements
- R1: After reset the access word reads 0x00000000, `mdc` is 0 and `mdio_oe` is 0.
- R2: Writing a word with bit 31 = 1 while idle starts a transfer. Bit 31 reads 1 from the next cycle until the transfer completes, then reads 0.
- R3: Writing a word with bit 31 = 0 while idle has no effect: no MDC edge occurs and the access word is unchanged.
- R4: Any write while bit 31 reads 1 is ignored. The running frame, its addresses and the final result are those of the first word.
- R5: Bit 30 = 1 selects a write. The frame is driven on 64 consecutive MDC cycles, MSB first: 32 ones, 01, opcode 01, PHY address (word bits 25:21), register address (word bits 20:16), turnaround 10, then data (word bits 15:0). For example, 0xC0A09000 writes 0x9000 to register 0 of PHY 5.
- R6: Bit 30 = 0 selects a read. The first 46 bits are 32 ones, 01, opcode 10 and the two addresses, all driven. `mdio_oe` is 0 for the remaining 18 bit times: the turnaround and the data.
- R7: On a read, `mdio_i` is sampled at the rising MDC edges of bit times 48..63, MSB first. On completion these 16 bits replace word bits 15:0, and bits 30:16 keep the values written.
- R8: One MDC period lasts 2*HALF_DIV system clocks. `mdio_o` and a release of `mdio_oe` change only in the cycle in which MDC falls. MDC is low whenever no transfer runs.
- R9: After a write transfer completes, the word reads back as the written word with bit 31 cleared. Bits 29:26 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the access word |
| wr_data | input | 32 | Access word written |
| rd_data | output | 32 | Current access word (busy, direction, addresses, data) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | High while the controller drives MDIO |
| mdio_i | input | 1 | Management data sampled in |

## Verification
A wrong bit counter shows at the ports as a frame longer or shorter than 64 MDC rising edges, or as a busy flag that never clears. This becomes visible within one transfer, about 64*2*HALF_DIV cycles. A wrong direction flag or release point shows as `mdio_oe` dropping at a bit other than 46, or as returned data shifted by one position. A busy guard that leaks shows as a second frame, or as altered addresses in the word read back after completion.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int RD_DRIVEN  = 46;
  localparam int DATA_FIRST = 48;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} mdio_op_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input mdio_op_e op, input logic [4:0] phy, input logic [4:0] rg,
    input logic [15:0] dat);
    logic [1:0] code;
    logic [1:0] ta;
    code = (op == OP_WR) ? 2'b01 : 2'b10;
    ta   = (op == OP_WR) ? 2'b10 : 2'b00;
    return {{PRE_BITS{1'b1}}, 2'b01, code, phy, rg, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == LAST);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_stop_low_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  is_read,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  active,
  output logic                  done,
  output logic [15:0]           rdata
);
  logic [FRAME_BITS-1:0] sh;
  logic [CNT_W-1:0]      nbit;
  logic                  rd_q;

  assign done = active && fall && (nbit == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      nbit    <= '0;
      rd_q    <= 1'b0;
      active  <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else if (start && !active) begin
      sh      <= frame;
      nbit    <= '0;
      rd_q    <= is_read;
      active  <= 1'b1;
      mdio_o  <= frame[FRAME_BITS-1];
      mdio_oe <= 1'b1;
    end else if (active) begin
      if (rise) begin
        if (rd_q && nbit >= CNT_W'(DATA_FIRST))
          rdata <= {rdata[14:0], mdio_i};
        nbit <= nbit + 1'b1;
      end else if (done) begin
        active  <= 1'b0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end else if (fall) begin
        sh      <= sh << 1;
        mdio_o  <= sh[FRAME_BITS-2];
        mdio_oe <= !(rd_q && nbit >= CNT_W'(RD_DRIVEN));
      end
    end
  end

  p_bitcnt_r5: assert property (@(posedge clk) disable iff (rst)
    nbit <= CNT_W'(FRAME_BITS));
endmodule

// File: rtl/mdio_access_ctrl.sv
module mdio_access_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        busy_q;
  mdio_op_e    op_q;
  logic [4:0]  phy_q, reg_q;
  logic [15:0] dat_q;
  logic        start, run, rise, fall, done;
  logic [15:0] rword;
  logic [FRAME_BITS-1:0] frame;

  assign start = wr_en && wr_data[31] && !busy_q;
  assign frame = build_frame(mdio_op_e'(wr_data[30]), wr_data[25:21],
                             wr_data[20:16], wr_data[15:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      op_q   <= OP_RD;
      phy_q  <= '0;
      reg_q  <= '0;
      dat_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      op_q   <= mdio_op_e'(wr_data[30]);
      phy_q  <= wr_data[25:21];
      reg_q  <= wr_data[20:16];
      dat_q  <= wr_data[15:0];
    end else if (done) begin
      busy_q <= 1'b0;
      if (op_q == OP_RD) dat_q <= rword;
    end
  end

  assign rd_data = {busy_q, op_q, 4'b0000, phy_q, reg_q, dat_q};

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(run), .mdc(mdc), .rise(rise), .fall(fall));

  mdio_shifter u_shift (
    .clk(clk), .rst(rst), .start(start), .is_read(wr_data[30] == 1'b0),
    .frame(frame), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .active(run), .done(done),
    .rdata(rword));

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(wr_en && wr_data[31]));
  p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_en) |=> ($stable(phy_q) && $stable(reg_q) && $stable(op_q)));
  p_idle_mdc_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !mdc);
  p_mdio_fall_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> $fell(mdc));
endmodule

// File: tb/mdio_access_ctrl_tb.sv
module mdio_access_ctrl_tb;
  localparam int PERIOD   = 10;
  localparam int HALF_DIV = 2;
  localparam int NVEC     = 6;

  // each entry: access word, data returned by the PHY model on reads
  localparam logic [47:0] VEC [NVEC] = '{
    {32'hC0A09000, 16'h0000},
    {32'hC0C09000, 16'h0000},
    {32'h80C1_0000, 16'h786D},
    {32'h8020_0000, 16'hFFFF},
    {32'h8000_0000, 16'h0001},
    {32'hC3FF_A5A5, 16'h0000}
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, mdio_i = 1'b1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic mdc, mdio_o, mdio_oe;
  int errors = 0, checks = 0;
  int ridx = 0, base = 0;
  logic [15:0] phy_val = '0;
  logic cap_o [256];
  logic cap_oe [256];
  time  cap_t [256];

  always #(PERIOD/2) clk = ~clk;

  mdio_access_ctrl #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  always @(posedge mdc) begin
    cap_o[ridx[7:0]]  <= mdio_o;
    cap_oe[ridx[7:0]] <= mdio_oe;
    cap_t[ridx[7:0]]  <= $time;
    ridx <= ridx + 1;
  end

  always @(negedge mdc) begin
    int k;
    k = ridx - base;
    if (k >= 48 && k < 64) mdio_i <= phy_val[63 - k];
    else if (k == 47)      mdio_i <= 1'b0;
    else                   mdio_i <= 1'b1;
  end

  initial begin
    #(PERIOD * 150000);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (rd_data[31] && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(n < 2000, "R2 busy clears", 64'(rd_data), 64'(0));
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    logic [1:0] code, ta;
    code = w[30] ? 2'b01 : 2'b10;
    ta   = w[30] ? 2'b10 : 2'b00;
    return {32'hFFFFFFFF, 2'b01, code, w[25:21], w[20:16], ta, w[15:0]};
  endfunction

  task automatic run_vec(input logic [31:0] w, input logic [15:0] pv);
    logic [63:0] ef, got;
    logic [31:0] er;
    int nd;
    bit oe_ok;
    phy_val = pv;
    base = ridx;
    put(w);
    chk(rd_data[31] == 1'b1, "R2 busy set", 64'(rd_data), 64'(1));
    wait_idle();
    chk(ridx - base == 64, "R5 frame length", 64'(ridx - base), 64'd64);
    ef = exp_frame(w);
    nd = w[30] ? 64 : 46;
    got = '0; oe_ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      got[63 - i] = cap_o[8'(base + i)];
      if (cap_oe[8'(base + i)] != (i < nd)) oe_ok = 1'b0;
    end
    if (w[30]) begin
      chk(got == ef, "R5 write frame bits", got, ef);
      chk(oe_ok, "R5 driven all 64 bits", 64'(oe_ok), 64'(1));
      er = {1'b0, w[30:0]};
      chk(rd_data == er, "R9 word after write", 64'(rd_data), 64'(er));
    end else begin
      chk(got[63:18] == ef[63:18], "R6 read header bits", got, ef);
      chk(oe_ok, "R6 release from turnaround", 64'(oe_ok), 64'(1));
      er = {2'b00, 4'b0000, w[25:16], pv};
      chk(rd_data == er, "R7 read data in low half", 64'(rd_data), 64'(er));
    end
  endtask

  initial begin
    logic [31:0] snap;
    int r0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 32'h0 && !mdc && !mdio_oe, "R1 reset state",
        {mdc, mdio_oe, 30'b0, rd_data}, 64'(0));

    for (int v = 0; v < NVEC; v++) run_vec(VEC[v][47:16], VEC[v][15:0]);

    // R8: MDC period measured between consecutive rising edges
    chk(cap_t[8'(ridx - 2)] - cap_t[8'(ridx - 3)] == 2 * HALF_DIV * PERIOD,
        "R8 mdc period", 64'(cap_t[8'(ridx - 2)] - cap_t[8'(ridx - 3)]),
        64'(2 * HALF_DIV * PERIOD));

    // R3: write without start bit
    snap = rd_data; r0 = ridx;
    put(32'h40A0_1234);
    repeat (40) @(negedge clk);
    chk(rd_data == snap && ridx == r0 && !mdc, "R3 no start ignored",
        64'(rd_data), 64'(snap));

    // R4: write during busy ignored
    phy_val = 16'hBEEF;
    base = ridx;
    put(32'h8062_0000);
    repeat (30) @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'hC0A0_FFFF;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    wait_idle();
    chk(rd_data == 32'h0062_BEEF, "R4 busy write ignored", 64'(rd_data),
        64'h0062_BEEF);
    r0 = ridx;
    repeat (60) @(negedge clk);
    chk(ridx - base == 64 && ridx == r0, "R4 no second frame",
        64'(ridx - base), 64'd64);
    chk(!mdc && !mdio_oe, "R8 idle mdc low", {mdc, mdio_oe}, 64'(0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule